// File: doc/BRIEF.md
# Text-Mode Raster Renderer

This block produces the scan timing for a 640x480 display refreshed at 60 Hz and paints a monochrome text screen on it. A single clock is used, and a pixel-rate enable strobe advances the scan. The enable runs at 25 MHz when the clock runs at 50 MHz. The screen is a grid of 80 by 30 character cells, and each cell is 8 pixels wide and 16 lines tall. Each cell shows the glyph whose font code is held in an on-block character store.

A host updates the store with single 32-bit bus writes. A write is taken only when its address equals the block's assigned address. The data word packs the cell position and the font code, so one bus transfer updates one cell.

Each pixel passes through two registered reads. The first read fetches the cell's code. The second fetches one glyph row from a test font generator. A final register then picks one pixel out of that row. The block delays the sync and blank signals by the same number of pixels, so they stay aligned with the picture.

Top module: `txt_raster`

## Requirements
- R1: While reset is held, and for the first three pixel strobes after reset, the outputs are hsync_n=1, vsync_n=1, blank=1 and pixel=0.
- R2: A horizontal counter h counts strobes from 0 to H_VIS+H_FP+H_SYNC+H_BP-1 and then wraps to 0. hsync_n is low, active low, exactly while H_VIS+H_FP <= h < H_VIS+H_FP+H_SYNC.
- R3: A vertical counter v advances by one only on the strobe where h wraps. It counts from 0 to V_VIS+V_FP+V_SYNC+V_BP-1 and then wraps. vsync_n is low exactly while V_VIS+V_FP <= v < V_VIS+V_FP+V_SYNC.
- R4: blank is high whenever h >= H_VIS or v >= V_VIS. pixel is always 0 while blank is high.
- R5: For a visible position, the cell shown is column h/8 and row v/16. The code used is the code last written for that column and row.
- R6: Glyph row r (0 to 15) of code c is the byte c XOR (17*r mod 256). Bit 7 of that byte is the leftmost pixel of the cell, and pixel equals bit (7 - h mod 8).
- R7: A write word holds the cell row in bits 31:27, the cell column in bits 26:20 and the font code in bits 19:12. Bits 11:0 have no effect.
- R8: A write whose address differs from BASE_ADDR does not change any stored code.
- R9: All outputs show position n = K-3, where K is the number of strobes since reset. hsync_n, vsync_n and blank are delayed by the same three strobes as pixel.
- R10: While pix_en is low, no output changes.
- R11: A write to a column beyond the visible columns, or to a row beyond the visible rows, changes no visible cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| pix_en | input | 1 | Pixel-rate strobe that advances the scan |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | BUS_AW | Bus write address, compared with BASE_ADDR |
| wr_data | input | 32 | Packed word holding the cell position and the font code |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| pixel | output | 1 | Monochrome pixel value |

## Verification
The bench builds the block with a reduced scan. The visible area is 64 by 48 pixels, which is 8 columns by 3 rows of cells, with short porches and short sync pulses. A whole frame therefore lasts 4400 strobes. This size lets several complete frames run and be compared pixel by pixel against a model in the bench, including every sync edge, the frame wrap and the cells at the right and bottom edges. The same size also leaves columns and rows in the store that the scan never reaches. Writes to those cells can then be shown to stay invisible.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int COL_W  = 7;
  localparam int ROW_W  = 5;
  localparam int CODE_W = 8;
  localparam int LINE_W = 4;
  localparam int CELL_W = 8;
  localparam int IDX_W  = ROW_W + COL_W;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [CODE_W-1:0] code;
    logic [11:0]       unused;
  } wr_word_t;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic blank;
  } scan_ctl_t;

  function automatic logic [CELL_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                  input logic [LINE_W-1:0] line);
    glyph_row = code ^ {line, line};
  endfunction
endpackage

// File: rtl/txt_timing.sv
module txt_timing
  import txt_pkg::*;
#(
  parameter int H_VIS = 640, parameter int H_FP = 16, parameter int H_SYNC = 96, parameter int H_BP = 48,
  parameter int V_VIS = 480, parameter int V_FP = 10, parameter int V_SYNC = 2,  parameter int V_BP = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output scan_ctl_t     ctl_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_VEND = HW'(H_VIS);
  localparam logic [VW-1:0] V_VEND = VW'(V_VIS);
  localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (pix_en) begin
      if (h_q == H_LAST) begin
        h_d = '0;
        v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  always_comb begin
    ctl_o.hs_n  = !((h_q >= HS_BEG) && (h_q < HS_END));
    ctl_o.vs_n  = !((v_q >= VS_BEG) && (v_q < VS_END));
    ctl_o.blank = (h_q >= H_VEND) || (v_q >= V_VEND);
  end

  assign h_o = h_q;
  assign v_o = v_q;

  // R2
  h_range_chk: assert property (@(posedge clk) disable iff (!rst_n) h_q <= H_LAST);
  // R3
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && h_q == H_LAST) |=> $stable(v_q));
  // R10
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_q) && $stable(v_q)));
endmodule

// File: rtl/txt_charmem.sv
module txt_charmem
  import txt_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter logic [BUS_AW-1:0] BASE_ADDR = 32'h0000_0400,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  output logic [CODE_W-1:0] rd_code_o
);
  logic [CODE_W-1:0] mem [DEPTH];
  wr_word_t          word;
  logic              hit;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [CODE_W-1:0] code_q, code_d;

  assign word   = wr_word_t'(wr_data);
  assign hit    = wr_en && (wr_addr == BASE_ADDR);
  assign wr_idx = {word.row, word.col};
  assign rd_idx = {rd_row, rd_col};

  always_ff @(posedge clk) begin
    if (hit) mem[wr_idx] <= word.code;
  end

  always_comb code_d = rd_en ? mem[rd_idx] : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign rd_code_o = code_q;

  // R8
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != BASE_ADDR) |-> !hit);
endmodule

// File: rtl/txt_font.sv
module txt_font
  import txt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [LINE_W-1:0] line,
  output logic [CELL_W-1:0] bits_o
);
  logic [CELL_W-1:0] bits_q, bits_d;

  always_comb bits_d = en ? glyph_row(code, line) : bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/txt_raster.sv
module txt_raster
  import txt_pkg::*;
#(
  parameter int H_VIS = 640, parameter int H_FP = 16, parameter int H_SYNC = 96, parameter int H_BP = 48,
  parameter int V_VIS = 480, parameter int V_FP = 10, parameter int V_SYNC = 2,  parameter int V_BP = 33,
  parameter int BUS_AW = 32,
  parameter logic [BUS_AW-1:0] BASE_ADDR = 32'h0000_0400,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT),
  localparam int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic              pixel
);
  localparam scan_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, blank: 1'b1};

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  scan_ctl_t     ctl0;

  txt_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_q), .pix_en(pix_en),
    .h_o(h_cnt), .v_o(v_cnt), .ctl_o(ctl0)
  );

  logic [COL_W-1:0]  cell_col;
  logic [ROW_W-1:0]  cell_row;
  logic [CODE_W-1:0] code1;
  logic [CELL_W-1:0] bits2;

  assign cell_col = COL_W'(h_cnt >> 3);
  assign cell_row = ROW_W'(v_cnt >> 4);

  txt_charmem #(.BUS_AW(BUS_AW), .BASE_ADDR(BASE_ADDR)) u_charmem (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(pix_en), .rd_row(cell_row), .rd_col(cell_col), .rd_code_o(code1)
  );

  logic [2:0]        xoff1, xoff2;
  logic [LINE_W-1:0] line1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff1 <= '0;
      line1 <= '0;
      xoff2 <= '0;
    end else if (pix_en) begin
      xoff1 <= h_cnt[2:0];
      line1 <= v_cnt[3:0];
      xoff2 <= xoff1;
    end
  end

  txt_font u_font (
    .clk(clk), .rst_n(rst_q), .en(pix_en),
    .code(code1), .line(line1), .bits_o(bits2)
  );

  scan_ctl_t ctl_pipe [LAT+1];
  assign ctl_pipe[0] = ctl0;

  for (genvar g = 1; g <= LAT; g++) begin : g_ctl_dly
    scan_ctl_t stg_q, stg_d;
    always_comb stg_d = pix_en ? ctl_pipe[g-1] : stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg_q <= CTL_IDLE;
      else if (!rst_q) stg_q <= CTL_IDLE;
      else             stg_q <= stg_d;
    end
    assign ctl_pipe[g] = stg_q;
  end

  logic pix_q, pix_d;
  always_comb begin
    pix_d = pix_q;
    if (pix_en) pix_d = bits2[3'd7 - xoff2] & !ctl_pipe[LAT-1].blank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pix_q <= 1'b0;
    else if (!rst_q) pix_q <= 1'b0;
    else             pix_q <= pix_d;
  end

  assign hsync_n = ctl_pipe[LAT].hs_n;
  assign vsync_n = ctl_pipe[LAT].vs_n;
  assign blank   = ctl_pipe[LAT].blank;
  assign pixel   = pix_q;

  // R4
  dark_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_q) blank |-> !pixel);
  // R4
  hsync_blanked_chk: assert property (@(posedge clk) disable iff (!rst_q) !hsync_n |-> blank);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !pix_en |=> ($stable(pixel) && $stable(blank) && $stable(hsync_n) && $stable(vsync_n)));
endmodule

// File: tb/txt_raster_test.sv
module txt_raster_test;
  localparam int H_VIS = 64, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_VIS = 48, V_FP = 2, V_SYNC = 2, V_BP = 3;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, pix_en, wr_en;
  logic [31:0] wr_addr, wr_data;
  logic        hsync_n, vsync_n, blank, pixel;

  txt_raster #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .BUS_AW(32), .BASE_ADDR(BASE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pixel(pixel)
  );

  logic [7:0] model [4096];
  int nchk = 0, nerr = 0, k = 0;
  string ptag = "R5 R6 R7";

  function automatic logic [7:0] glyph(input logic [7:0] c, input int r);
    return c ^ 8'((17 * r) % 256);
  endfunction

  function automatic logic [31:0] mkword(input int row, input int col, input logic [7:0] c,
                                         input logic [11:0] low);
    return {5'(row), 7'(col), c, low};
  endfunction

  task automatic cmp(input logic act, input logic exp, input string tag, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s at strobe %0d: actual=%b expected=%b", tag, what, k, act, exp);
    end
  endtask

  task automatic check_all(input string extra);
    logic e_hs, e_vs, e_bl, e_px;
    int n, h, v, idx;
    if (k < 3) begin
      e_hs = 1; e_vs = 1; e_bl = 1; e_px = 0;
      cmp(hsync_n, e_hs, {"R1 R9", extra}, "hsync_n");
      cmp(vsync_n, e_vs, {"R1 R9", extra}, "vsync_n");
      cmp(blank, e_bl, {"R1 R9", extra}, "blank");
      cmp(pixel, e_px, {"R1 R9", extra}, "pixel");
    end else begin
      n = (k - 3) % (H_TOT * V_TOT);
      h = n % H_TOT;
      v = n / H_TOT;
      e_hs = !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC);
      e_vs = !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC);
      e_bl = (h >= H_VIS) || (v >= V_VIS);
      if (e_bl) e_px = 0;
      else begin
        idx = (v / 16) * 128 + (h / 8);
        e_px = glyph(model[idx], v % 16)[7 - (h % 8)];
      end
      cmp(hsync_n, e_hs, {"R2 R9", extra}, "hsync_n");
      cmp(vsync_n, e_vs, {"R3 R9", extra}, "vsync_n");
      cmp(blank, e_bl, {"R4 R9", extra}, "blank");
      cmp(pixel, e_px, {ptag, " R4", extra}, "pixel");
    end
  endtask

  task automatic step();
    @(negedge clk) pix_en = 1'b1;
    @(negedge clk) pix_en = 1'b0;
    k++;
    #5 check_all("");
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    if (a == BASE) model[{d[31:27], d[26:20]}] = d[19:12];
  endtask

  initial begin
    #(190000 * 20);
    nerr++;
    $display("FAIL watchdog expired at strobe %0d: actual=running expected=done", k);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    rst_n = 1'b0; pix_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    #5 check_all(" reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // fill every visible cell with random codes, then directed corner codes
    for (int r = 0; r < V_VIS / 16; r++)
      for (int c = 0; c < H_VIS / 8; c++)
        bus_write(BASE, mkword(r, c, 8'($urandom), 12'h000));
    bus_write(BASE, mkword(0, 0, 8'h00, 12'h000));
    bus_write(BASE, mkword(0, 1, 8'hFF, 12'h000));
    // R7: low bits set are ignored
    bus_write(BASE, mkword(1, 7, 8'hA5, 12'hFFF));
    // R8: stray address must not reach cell (0,0) or (2,7)
    bus_write(BASE + 32'h4, mkword(0, 0, 8'h5A, 12'h000));
    bus_write(32'h0, mkword(2, 7, 8'h3C, 12'h000));
    // R11: cells outside the visible grid
    bus_write(BASE, mkword(0, 100, 8'hEE, 12'h000));
    bus_write(BASE, mkword(31, 0, 8'h77, 12'h000));
    ptag = "R5 R6 R7 R8 R11";

    for (int s = 0; s < H_TOT * V_TOT + 500; s++) step();

    // R10: pause with the strobe low; outputs must hold
    repeat (7) @(negedge clk);
    #5 check_all(" R10 pause");

    for (int s = 0; s < H_TOT * V_TOT; s++) step();

    // rewrite a few cells with random codes, then scan another frame
    for (int i = 0; i < 6; i++)
      bus_write(BASE, mkword(int'($urandom % 3), int'($urandom % 8), 8'($urandom), 12'($urandom)));
    ptag = "R5 R6 R7";
    for (int s = 0; s < H_TOT * V_TOT; s++) step();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule